// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C master. It alternates a driven-low phase and a released phase. Each phase lasts a programmable number of count ticks. A count tick is either every input clock cycle or every second cycle, chosen by a select input. Each phase count is nine bits wide: an eight-bit base value plus a separate ninth bit. The ninth bit takes effect only when an extension enable is set.

The low phase is timed from the first cycle in which the block pulls SCL low. The high phase is different. After release, the block waits, for as long as it takes, until the sampled SCL input reads high. Only then does it start timing the high phase. This way, a slow rise or a slave that stretches the clock never shortens the high time.

A byte engine drives the run request. It uses a falling-edge strobe to change SDA and a rising-edge strobe to sample it. When the run request is withdrawn, the block completes the phase it is in and then leaves SCL released.

Top module: `i2c_scl_timer`

## Requirements
- R1: The effective count of a phase is the nine-bit value {msb, base}, where msb is the phase's ninth bit ANDed with `msb_en`. With `msb_en` low the largest count is 255, and with it high the largest is 511. An effective value of zero acts as one.
- R2: `scl_drive_low` stays high for exactly (low count x D) consecutive clock cycles, where D is the divide factor from R4.
- R3: The number of clock cycles from the `scl_rise_stb` pulse to the next `scl_fall_stb` pulse is exactly (high count x D).
- R4: D is 1 when `div2_sel` is 0 and 2 when `div2_sel` is 1.
- R5: While SCL is released but `scl_in` still samples low, `stretch_act` is high, with no time limit. `scl_rise_stb` pulses for one cycle in the cycle after `scl_in` is first sampled high, and `stretch_act` drops in that same cycle.
- R6: `scl_fall_stb` is a one-cycle pulse in the first cycle of every low phase and at no other time. It is never high in the same cycle as `scl_rise_stb`.
- R7: If `run_req` is low when a low phase ends, that phase still runs its full length. SCL is then released and stays released with no strobes and no `stretch_act`.
- R8: While `rst_n` is low, and afterwards until `run_req` is seen high, all outputs are 0.
- R9: When `run_req` is sampled high while idle, `scl_drive_low` and `scl_fall_stb` go high in the next cycle.
- R10: If `run_req` is low when a high phase expires, no new low phase starts and SCL remains released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_base | input | BASE_W | Low-phase count, lower bits |
| hi_base | input | BASE_W | High-phase count, lower bits |
| lo_msb | input | 1 | Low-phase count, ninth bit |
| hi_msb | input | 1 | High-phase count, ninth bit |
| msb_en | input | 1 | Enables both ninth bits |
| div2_sel | input | 1 | 1: count tick every second cycle |
| run_req | input | 1 | Keep generating clock periods |
| scl_in | input | 1 | Synchronised SCL pad level |
| scl_drive_low | output | 1 | Pull SCL low |
| scl_fall_stb | output | 1 | Pulse at start of each low phase |
| scl_rise_stb | output | 1 | Pulse once SCL is sensed high |
| stretch_act | output | 1 | Released but SCL still low |

## Verification
The bench models the bus line with a rise-plus-stretch delay. It attacks these cases:
- Zero counts: a design that mishandled them would make a phase of zero or 256 ticks.
- A set ninth bit with the enable off: a design that did not gate it would add 256 ticks.
- The 511-tick maximum at half rate: it exposes a counter that is too narrow or wraps.
- Long stretches: a design that timed the high phase from release would shorten the high time by the stretch length, and a design with a stretch limit would cut the stretch off early.
- Withdrawing `run_req` in the middle of a low phase and in the middle of a high phase: these catch a design that truncates the low phase or emits a stray fall strobe.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;
  // Phase of the serial clock sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // released, no clocking
    PH_LOW  = 2'd1,  // driving SCL low, timing low count
    PH_WAIT = 2'd2,  // released, waiting for the line to read high
    PH_HIGH = 2'd3   // line seen high, timing high count
  } scl_phase_e;
endpackage

// File: rtl/i2c_scl_count_fmt.sv
// Forms the effective nine-bit phase count; zero is promoted to one.
module i2c_scl_count_fmt #(
  parameter int BASE_W = 8,
  parameter int CNT_W  = BASE_W + 1
) (
  input  logic [BASE_W-1:0] base,
  input  logic              msb,
  input  logic              msb_en,
  output logic [CNT_W-1:0]  eff
);
  logic [CNT_W-1:0] raw;

  always_comb begin
    raw = {msb & msb_en, base};
    eff = (raw == '0) ? CNT_W'(1) : raw;
  end
endmodule

// File: rtl/i2c_scl_prescale.sv
// Count-tick generator: every cycle, or once per 2**PRE_W cycles when slow_sel.
// Restart aligns the tick grid to the start of a phase.
module i2c_scl_prescale #(
  parameter int PRE_W = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic slow_sel,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;

  always_comb begin
    if (restart || !slow_sel) pre_d = '0;
    else                      pre_d = pre_q + PRE_W'(1);
    tick = !slow_sel || (pre_q == PRE_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/i2c_scl_phase_cnt.sv
// Counts ticks within a phase; done marks the tick that completes `limit` ticks.
module i2c_scl_phase_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || tick;
    cnt_d  = restart ? '0 : cnt_q + CNT_W'(1);
    done   = tick && (cnt_q >= limit - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import i2c_scl_timer_pkg::*;
#(
  parameter int BASE_W = 8,
  parameter int PRE_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] lo_base,
  input  logic [BASE_W-1:0] hi_base,
  input  logic              lo_msb,
  input  logic              hi_msb,
  input  logic              msb_en,
  input  logic              div2_sel,
  input  logic              run_req,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              scl_fall_stb,
  output logic              scl_rise_stb,
  output logic              stretch_act
);
  localparam int CNT_W = BASE_W + 1;

  scl_phase_e       phase_q;
  scl_phase_e       phase_d;
  logic [CNT_W-1:0] lo_eff;
  logic [CNT_W-1:0] hi_eff;
  logic [CNT_W-1:0] ph_limit;
  logic             restart;
  logic             tick;
  logic             ph_done;
  logic             fall_d;
  logic             rise_d;
  logic             fall_q;
  logic             rise_q;

  i2c_scl_count_fmt #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_lo_fmt (
    .base(lo_base), .msb(lo_msb), .msb_en(msb_en), .eff(lo_eff)
  );

  i2c_scl_count_fmt #(.BASE_W(BASE_W), .CNT_W(CNT_W)) u_hi_fmt (
    .base(hi_base), .msb(hi_msb), .msb_en(msb_en), .eff(hi_eff)
  );

  i2c_scl_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .slow_sel(div2_sel), .tick(tick)
  );

  i2c_scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(ph_limit), .done(ph_done)
  );

  // Next phase
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (run_req) phase_d = PH_LOW;
      PH_LOW:  if (ph_done) phase_d = run_req ? PH_WAIT : PH_IDLE;
      PH_WAIT: if (scl_in)  phase_d = PH_HIGH;
      PH_HIGH: if (ph_done) phase_d = run_req ? PH_LOW : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    ph_limit = (phase_q == PH_HIGH) ? hi_eff : lo_eff;
    restart  = (phase_d != phase_q);
    fall_d   = (phase_d == PH_LOW)  && (phase_q != PH_LOW);
    rise_d   = (phase_d == PH_HIGH) && (phase_q != PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      fall_q  <= fall_d;
      rise_q  <= rise_d;
    end
  end

  assign scl_drive_low = (phase_q == PH_LOW);
  assign stretch_act   = (phase_q == PH_WAIT);
  assign scl_fall_stb  = fall_q;
  assign scl_rise_stb  = rise_q;
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
  parameter int BASE_W = 8,
  parameter int PRE_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BASE_W-1:0] lo_base,
  input logic [BASE_W-1:0] hi_base,
  input logic              lo_msb,
  input logic              hi_msb,
  input logic              msb_en,
  input logic              div2_sel,
  input logic              run_req,
  input logic              scl_in,
  input logic              scl_drive_low,
  input logic              scl_fall_stb,
  input logic              scl_rise_stb,
  input logic              stretch_act
);
  localparam int LEN_W = BASE_W + PRE_W + 2;

  logic [LEN_W-1:0] lo_len_q;
  logic [LEN_W-1:0] hi_len_q;
  logic             hi_arm_q;
  logic [LEN_W-1:0] exp_lo;
  logic [LEN_W-1:0] exp_hi;

  function automatic logic [LEN_W-1:0] ref_len(input logic [BASE_W-1:0] b,
                                               input logic m, input logic en,
                                               input logic d2);
    logic [LEN_W-1:0] v;
    v = {{(LEN_W-BASE_W-1){1'b0}}, m & en, b};
    if (v == '0) v = LEN_W'(1);
    return d2 ? (v << PRE_W) : v;
  endfunction

  always_comb begin
    exp_lo = ref_len(lo_base, lo_msb, msb_en, div2_sel);
    exp_hi = ref_len(hi_base, hi_msb, msb_en, div2_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_len_q <= '0;
      hi_len_q <= '0;
      hi_arm_q <= 1'b0;
    end else begin
      lo_len_q <= scl_drive_low ? lo_len_q + LEN_W'(1) : '0;
      if (scl_rise_stb) begin
        hi_arm_q <= 1'b1;
        hi_len_q <= LEN_W'(1);
      end else if (scl_fall_stb || !run_req) begin
        hi_arm_q <= 1'b0;
      end else if (hi_arm_q) begin
        hi_len_q <= hi_len_q + LEN_W'(1);
      end
    end
  end

  a_r2_low_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && $past(scl_drive_low)) |-> (lo_len_q == exp_lo));

  a_r3_high_length: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall_stb && hi_arm_q) |-> (hi_len_q == exp_hi));

  a_r5_rise_after_sense: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_stb |-> ($past(scl_in) && $past(stretch_act) && !stretch_act));

  a_r5_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_act |-> !scl_drive_low);

  a_r6_fall_at_low_start: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_stb |-> (scl_drive_low && !$past(scl_drive_low)));

  a_r6_strobes_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_fall_stb && scl_rise_stb));

  a_r7_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_drive_low) && !$past(run_req)) |-> (!stretch_act && !scl_rise_stb));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.BASE_W(BASE_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_base(lo_base), .hi_base(hi_base),
  .lo_msb(lo_msb), .hi_msb(hi_msb), .msb_en(msb_en), .div2_sel(div2_sel),
  .run_req(run_req), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
  .scl_fall_stb(scl_fall_stb), .scl_rise_stb(scl_rise_stb),
  .stretch_act(stretch_act)
);

// File: tb/i2c_scl_timer_test.sv
module i2c_scl_timer_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] lo_base, hi_base;
  logic       lo_msb, hi_msb, msb_en, div2_sel, run_req;
  logic       scl_in = 1'b1;
  logic       scl_drive_low, scl_fall_stb, scl_rise_stb, stretch_act;

  int hold = 0;
  int ini_chk = 0, ini_err = 0, mon_chk = 0, mon_err = 0;

  always #5 clk = ~clk;

  i2c_scl_timer uut (
    .clk(clk), .rst_n(rst_n), .lo_base(lo_base), .hi_base(hi_base),
    .lo_msb(lo_msb), .hi_msb(hi_msb), .msb_en(msb_en), .div2_sel(div2_sel),
    .run_req(run_req), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .scl_fall_stb(scl_fall_stb), .scl_rise_stb(scl_rise_stb),
    .stretch_act(stretch_act)
  );

  // Expected phase length in clock cycles (R1, R4)
  function automatic int span(input logic [7:0] b, input logic m,
                              input logic en, input logic d2);
    int v;
    v = (m && en) ? 256 + int'(b) : int'(b);
    if (v == 0) v = 1;
    return d2 ? 2 * v : v;
  endfunction

  task automatic chk_m(input bit ok, input string rq, input int act, input int exp);
    mon_chk++;
    if (!ok) begin
      mon_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic chk_i(input bit ok, input string rq, input int act, input int exp);
    ini_chk++;
    if (!ok) begin
      ini_err++;
      $display("FAIL %s actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Bus model and timing monitor
  int lo_run = 0, st_run = 0, hi_cnt = 0, rel_cnt = 0;
  bit prev_dl = 0, prev_st = 0, hi_act = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      lo_run = 0; st_run = 0; hi_act = 0; prev_dl = 0; prev_st = 0;
      rel_cnt = 1000; scl_in = 1'b1;
    end else begin
      if (scl_drive_low) begin
        rel_cnt = 0; scl_in = 1'b0;
      end else begin
        rel_cnt++; scl_in = (rel_cnt > hold);
      end
      // R2 low length, including a final low phase after a stop (R7)
      if (scl_drive_low) lo_run++;
      else if (prev_dl) begin
        chk_m(lo_run == span(lo_base, lo_msb, msb_en, div2_sel), "R2", lo_run,
              span(lo_base, lo_msb, msb_en, div2_sel));
        lo_run = 0;
      end
      // R6 fall strobe only at low start
      if (scl_drive_low && !prev_dl) chk_m(scl_fall_stb, "R6", scl_fall_stb, 1);
      else if (scl_fall_stb) chk_m(1'b0, "R6", 1, 0);
      // R5 stretch length and rise strobe
      if (stretch_act) st_run++;
      else if (prev_st) begin
        chk_m(scl_rise_stb && st_run == hold + 1, "R5", st_run, hold + 1);
        st_run = 0;
      end
      // R3 high length measured from rise strobe
      if (!run_req) hi_act = 0;
      else if (scl_rise_stb) begin
        hi_act = 1; hi_cnt = 1;
      end else if (hi_act) begin
        if (scl_fall_stb) begin
          chk_m(hi_cnt == span(hi_base, hi_msb, msb_en, div2_sel), "R3", hi_cnt,
                span(hi_base, hi_msb, msb_en, div2_sel));
          hi_act = 0;
        end else hi_cnt++;
      end
      prev_dl = scl_drive_low;
      prev_st = stretch_act;
    end
  end

  task automatic chk_idle(input int n, input string rq);
    int bad = 0;
    repeat (n) begin
      @(negedge clk);
      if (scl_drive_low || scl_fall_stb || scl_rise_stb || stretch_act) bad++;
    end
    chk_i(bad == 0, rq, bad, 0);
  endtask

  task automatic set_cfg(input logic [7:0] lb, input logic lm, input logic [7:0] hb,
                         input logic hm, input logic en, input logic d2, input int h);
    @(posedge clk); #1;
    lo_base = lb; lo_msb = lm; hi_base = hb; hi_msb = hm;
    msb_en = en; div2_sel = d2; hold = h;
  endtask

  // R9: low phase begins the cycle after run_req is sampled
  task automatic start_run();
    @(posedge clk); #1 run_req = 1'b1;
    @(negedge clk);
    chk_i(!scl_drive_low, "R9", scl_drive_low, 0);
    @(negedge clk);
    chk_i(scl_drive_low && scl_fall_stb, "R9", {scl_drive_low, scl_fall_stb}, 3);
  endtask

  task automatic run_seg(input logic [7:0] lb, input logic lm, input logic [7:0] hb,
                         input logic hm, input logic en, input logic d2, input int h,
                         input int nfall);
    int settle;
    set_cfg(lb, lm, hb, hm, en, d2, h);
    start_run();
    repeat (nfall) @(posedge scl_fall_stb);
    @(posedge clk); #1 run_req = 1'b0;
    settle = span(lb, lm, en, d2) + span(hb, hm, en, d2) + h + 10;
    repeat (settle) @(posedge clk);
    chk_idle(20, "R7");
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd977);
    rst_n = 1'b0; run_req = 1'b0;
    lo_base = 8'd4; hi_base = 8'd4; lo_msb = 0; hi_msb = 0; msb_en = 0; div2_sel = 0;
    repeat (3) @(negedge clk);
    chk_i(!scl_drive_low && !scl_fall_stb && !scl_rise_stb && !stretch_act, "R8",
          {scl_drive_low, scl_fall_stb, scl_rise_stb, stretch_act}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    chk_idle(10, "R8");

    run_seg(8'd6, 0, 8'd4, 0, 0, 0, 0, 3);        // R2 R3 basic
    run_seg(8'd6, 0, 8'd4, 0, 0, 1, 2, 3);        // R4 half rate
    run_seg(8'd0, 0, 8'd0, 0, 0, 0, 1, 3);        // R1 zero acts as one
    run_seg(8'd5, 1, 8'd3, 1, 0, 0, 0, 3);        // R1 ninth bit ignored
    run_seg(8'd255, 1, 8'd255, 1, 1, 1, 3, 2);    // R1 maximum 511, R4
    run_seg(8'd3, 0, 8'd3, 0, 0, 0, 60, 3);       // R5 long stretch

    // R7: stop in the middle of a low phase; full length checked as R2
    set_cfg(8'd20, 0, 8'd6, 0, 0, 0, 1);
    start_run();
    @(posedge scl_fall_stb);
    repeat (5) @(posedge clk);
    #1 run_req = 1'b0;
    chk_i(scl_drive_low, "R7", scl_drive_low, 1);
    wait (!scl_drive_low);
    chk_idle(60, "R7");

    // R10: stop in the middle of a high phase
    set_cfg(8'd4, 0, 8'd30, 0, 0, 0, 2);
    start_run();
    @(posedge scl_rise_stb);
    @(posedge clk); #1 run_req = 1'b0;
    chk_idle(80, "R10");

    // Random segments
    for (int s = 0; s < 20; s++) begin
      run_seg(8'($urandom % 24), 1'($urandom % 2), 8'($urandom % 24), 1'($urandom % 2),
              (s % 5) == 0, 1'($urandom % 2), int'($urandom % 12), 3);
    end

    $display("CHECKS %0d ERRORS %0d", ini_chk + mon_chk, ini_err + mon_err);
    $finish;
  end

  initial begin
    #2000000;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", ini_chk + mon_chk + 1, ini_err + mon_err + 1);
    $finish;
  end
endmodule